// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

This block is the byte mailbox between a host I/O bus and a local controller in an 8042-style keyboard controller. The host writes bytes through a data strobe or a command strobe, reads the pending output byte, and always sees an eight-bit status byte. The local controller receives host bytes as a valid/ready stream, with a flag that tells whether each byte came in through the command port. It sends bytes back to the host through two valid/ready streams, one for keyboard data and one for auxiliary (mouse) data, and it can flush the output buffer.

The block raises three signals toward the two sides. The local side gets a level interrupt while an input byte waits, and a one-cycle pulse when the host empties the output buffer. The host gets a keyboard interrupt line that rests high. When a keyboard byte is sent with an interrupt request, that line stays high for one phase, goes low for one phase, and then returns high. The host therefore always sees a fresh falling edge. The phase length comes from the clock rate in MHz and a phase time in microseconds.

Back-pressure rules: the input stream is valid while a host byte is pending. A handshake (valid and ready in the same cycle) consumes that byte, and ready has no effect while valid is low. The byte and its command flag are presented together with valid, so both are captured in the same cycle as the handshake. A newer host write cannot split them. Each output stream is accepted only when its ready is high. Keyboard ready is high when the output buffer is empty and no flush is requested in that cycle. Auxiliary ready also needs the keyboard stream to be idle, so keyboard data has priority.

Top module: `kbc_mailbox`

## Requirements
- R1: After reset the status byte is 0x00, the keyboard interrupt line is high, irq_ibf and irq_obe are low, and status bits 2, 4, 6 and 7 always read 0.
- R2: A host write through the data strobe or the command strobe sets status bit 1 (input full) in the next cycle. It also sets status bit 3 to 1 for the command strobe and to 0 for the data strobe. The byte appears on loc_in_data with loc_in_is_cmd equal to bit 3.
- R3: A handshake on the input stream clears input full in the next cycle. If a host write arrives in the same cycle as the handshake, the handshake consumes the old byte, the new byte stays pending, and no overrun is recorded.
- R4: A host write while input full is set and no handshake occurs replaces the pending byte and sets loc_overrun. loc_overrun stays set until loc_ovr_clr is asserted in a cycle with no new overrun.
- R5: A keyboard-stream handshake sets status bit 0 (output full) and loads host_rdata. A host data read while bit 0 is set clears bit 0. loc_kb_ready is low while bit 0 is set.
- R6: An auxiliary-stream handshake sets both status bit 0 and status bit 5. Bit 5 is cleared by a keyboard load, by a host data read or by a flush. When both output streams are valid, the keyboard byte is taken and loc_aux_ready stays low.
- R7: irq_obe pulses high for exactly one cycle, one cycle after a host data read that finds bit 0 set. A read with bit 0 clear produces no pulse.
- R8: loc_flush clears bits 0 and 5 in the next cycle, produces no irq_obe pulse (even if a host data read occurs in the same cycle), and holds both output readies low in that cycle.
- R9: A keyboard handshake with loc_kb_irq set starts the interrupt sequence. The line is high for PHASE cycles, then low for PHASE cycles, then high again, where PHASE = CLK_MHZ*PHASE_US. A new request during an active sequence restarts it at the start of its high phase.
- R10: irq_ibf equals status bit 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_data | input | 1 | Host write strobe, data port |
| host_wr_cmd | input | 1 | Host write strobe, command port |
| host_wdata | input | DW | Host write byte |
| host_rd_data | input | 1 | Host read strobe, data port |
| host_rdata | output | DW | Pending output byte |
| host_status | output | 8 | Host status byte |
| loc_in_valid | output | 1 | Host byte pending |
| loc_in_ready | input | 1 | Local side takes the pending byte |
| loc_in_data | output | DW | Pending host byte |
| loc_in_is_cmd | output | 1 | Pending byte came through the command port |
| loc_overrun | output | 1 | Sticky overwrite flag |
| loc_ovr_clr | input | 1 | Clears the overwrite flag |
| loc_kb_valid | input | 1 | Keyboard byte offered |
| loc_kb_ready | output | 1 | Keyboard byte accepted |
| loc_kb_data | input | DW | Keyboard byte |
| loc_kb_irq | input | 1 | Request an interrupt sequence with this keyboard byte |
| loc_aux_valid | input | 1 | Auxiliary byte offered |
| loc_aux_ready | output | 1 | Auxiliary byte accepted |
| loc_aux_data | input | DW | Auxiliary byte |
| loc_flush | input | 1 | Discard the pending output byte |
| irq_ibf | output | 1 | Local interrupt, input byte pending |
| irq_obe | output | 1 | Local interrupt pulse, host emptied the output buffer |
| kbd_irq_line | output | 1 | Host keyboard interrupt, rests high |

## Verification
The assertions assume that the two host write strobes are never asserted in the same cycle and that every input is free of X after reset. The random stimulus picks at most one host write strobe per cycle, and every input is driven from a defined value. Nothing else about the host side is assumed, so reads of an empty buffer, writes onto a full input buffer and flushes that coincide with host reads are all generated. Restarts of the interrupt sequence are also generated, with requests landing in both the high phase and the low phase.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int unsigned ST_OBF = 0;
  localparam int unsigned ST_IBF = 1;
  localparam int unsigned ST_CMD = 3;
  localparam int unsigned ST_AUX = 5;

  typedef enum logic [1:0] {
    PL_IDLE = 2'd0,
    PL_HIGH = 2'd1,
    PL_LOW  = 2'd2
  } pulse_st_e;
endpackage

// File: rtl/kbc_inbox.sv
module kbc_inbox #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_data,
  input  logic          wr_cmd,
  input  logic [DW-1:0] wdata,
  input  logic          take,
  input  logic          ovr_clr,
  output logic          full,
  output logic [DW-1:0] data,
  output logic          is_cmd,
  output logic          overrun
);
  logic wr, consume, clash;

  assign wr      = wr_data | wr_cmd;
  assign consume = take & full;
  assign clash   = wr & full & ~consume;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full    <= 1'b0;
      data    <= '0;
      is_cmd  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      overrun <= (overrun & ~ovr_clr) | clash;
      if (wr) begin
        full   <= 1'b1;
        data   <= wdata;
        is_cmd <= wr_cmd;
      end else if (consume) begin
        full <= 1'b0;
      end
    end
  end

  a_r4_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(overrun) |-> $past(ovr_clr));
  a_r2_full_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(wr_data | wr_cmd));
  a_r3_empty_needs_take: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full) |-> $past(take));
endmodule

// File: rtl/kbc_outbox.sv
module kbc_outbox #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kb_valid,
  input  logic [DW-1:0] kb_data,
  output logic          kb_ready,
  input  logic          aux_valid,
  input  logic [DW-1:0] aux_data,
  output logic          aux_ready,
  input  logic          flush,
  input  logic          host_rd,
  output logic          obf,
  output logic          aux,
  output logic [DW-1:0] rdata,
  output logic          obe_pulse
);
  logic kb_take, aux_take;

  assign kb_ready  = ~obf & ~flush;
  assign aux_ready = kb_ready & ~kb_valid;
  assign kb_take   = kb_valid & kb_ready;
  assign aux_take  = aux_valid & aux_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obf       <= 1'b0;
      aux       <= 1'b0;
      rdata     <= '0;
      obe_pulse <= 1'b0;
    end else begin
      obe_pulse <= host_rd & obf & ~flush;
      if (flush) begin
        obf <= 1'b0;
        aux <= 1'b0;
      end else if (kb_take) begin
        obf   <= 1'b1;
        aux   <= 1'b0;
        rdata <= kb_data;
      end else if (aux_take) begin
        obf   <= 1'b1;
        aux   <= 1'b1;
        rdata <= aux_data;
      end else if (host_rd) begin
        obf <= 1'b0;
        aux <= 1'b0;
      end
    end
  end

  a_r6_aux_implies_full: assert property (@(posedge clk) disable iff (!rst_n)
    aux |-> obf);
  a_r7_obe_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    obe_pulse |-> ($past(obf) && !obf && $past(host_rd)));
  a_r7_obe_single: assert property (@(posedge clk) disable iff (!rst_n)
    obe_pulse |=> !obe_pulse);
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!obf && !aux && !obe_pulse));
endmodule

// File: rtl/kbc_irq_pulse.sv
module kbc_irq_pulse #(
  parameter int unsigned PHASE_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic line
);
  import kbc_pkg::*;
  localparam int unsigned CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(PHASE_CYC - 1);

  pulse_st_e     st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= PL_IDLE;
      cnt <= '0;
    end else if (req) begin
      st  <= PL_HIGH;
      cnt <= '0;
    end else if (st != PL_IDLE) begin
      if (cnt == LAST) begin
        cnt <= '0;
        st  <= (st == PL_HIGH) ? PL_LOW : PL_IDLE;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign line = (st != PL_LOW);

  a_r9_req_goes_high: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> line);
  a_r9_low_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line) |-> $past(st == PL_HIGH));
  a_r9_rise_ends_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line) |-> ($past(cnt == LAST) || $past(req)));
endmodule

// File: rtl/kbc_mailbox.sv
module kbc_mailbox #(
  parameter int unsigned DW       = 8,
  parameter int unsigned CLK_MHZ  = 50,
  parameter int unsigned PHASE_US = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr_data,
  input  logic          host_wr_cmd,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_rd_data,
  output logic [DW-1:0] host_rdata,
  output logic [7:0]    host_status,
  output logic          loc_in_valid,
  input  logic          loc_in_ready,
  output logic [DW-1:0] loc_in_data,
  output logic          loc_in_is_cmd,
  output logic          loc_overrun,
  input  logic          loc_ovr_clr,
  input  logic          loc_kb_valid,
  output logic          loc_kb_ready,
  input  logic [DW-1:0] loc_kb_data,
  input  logic          loc_kb_irq,
  input  logic          loc_aux_valid,
  output logic          loc_aux_ready,
  input  logic [DW-1:0] loc_aux_data,
  input  logic          loc_flush,
  output logic          irq_ibf,
  output logic          irq_obe,
  output logic          kbd_irq_line
);
  import kbc_pkg::*;
  localparam int unsigned PHASE_CYC = CLK_MHZ * PHASE_US;

  logic ibf, obf, aux_flag;

  kbc_inbox #(.DW(DW)) u_inbox (
    .clk(clk), .rst_n(rst_n),
    .wr_data(host_wr_data), .wr_cmd(host_wr_cmd), .wdata(host_wdata),
    .take(loc_in_ready), .ovr_clr(loc_ovr_clr),
    .full(ibf), .data(loc_in_data), .is_cmd(loc_in_is_cmd),
    .overrun(loc_overrun)
  );

  kbc_outbox #(.DW(DW)) u_outbox (
    .clk(clk), .rst_n(rst_n),
    .kb_valid(loc_kb_valid), .kb_data(loc_kb_data), .kb_ready(loc_kb_ready),
    .aux_valid(loc_aux_valid), .aux_data(loc_aux_data), .aux_ready(loc_aux_ready),
    .flush(loc_flush), .host_rd(host_rd_data),
    .obf(obf), .aux(aux_flag), .rdata(host_rdata), .obe_pulse(irq_obe)
  );

  kbc_irq_pulse #(.PHASE_CYC(PHASE_CYC)) u_pulse (
    .clk(clk), .rst_n(rst_n),
    .req(loc_kb_valid & loc_kb_ready & loc_kb_irq),
    .line(kbd_irq_line)
  );

  always_comb begin
    host_status         = 8'h00;
    host_status[ST_OBF] = obf;
    host_status[ST_IBF] = ibf;
    host_status[ST_CMD] = loc_in_is_cmd;
    host_status[ST_AUX] = aux_flag;
  end

  assign loc_in_valid = ibf;
  assign irq_ibf      = ibf;

  a_r2_one_write_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr_data && host_wr_cmd));
  a_r1_spare_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_status & 8'hD4) == 8'h00);
  a_r5_no_accept_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    host_status[ST_OBF] |-> !loc_kb_ready && !loc_aux_ready);
endmodule

// File: tb/kbc_mailbox_tb.sv
module kbc_mailbox_tb;
  localparam int PERIOD = 10;
  localparam int PH     = 50 * 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr_data = 0, host_wr_cmd = 0, host_rd_data = 0;
  logic [7:0] host_wdata = 0, loc_kb_data = 0, loc_aux_data = 0;
  logic loc_in_ready = 0, loc_ovr_clr = 0, loc_kb_valid = 0, loc_kb_irq = 0;
  logic loc_aux_valid = 0, loc_flush = 0;
  logic [7:0] host_rdata, host_status, loc_in_data;
  logic loc_in_valid, loc_in_is_cmd, loc_overrun, loc_kb_ready, loc_aux_ready;
  logic irq_ibf, irq_obe, kbd_irq_line;

  int n_chk = 0, n_bad = 0;

  always #(PERIOD/2) clk = ~clk;

  kbc_mailbox u_dut (
    .clk(clk), .rst_n(rst_n),
    .host_wr_data(host_wr_data), .host_wr_cmd(host_wr_cmd), .host_wdata(host_wdata),
    .host_rd_data(host_rd_data), .host_rdata(host_rdata), .host_status(host_status),
    .loc_in_valid(loc_in_valid), .loc_in_ready(loc_in_ready), .loc_in_data(loc_in_data),
    .loc_in_is_cmd(loc_in_is_cmd), .loc_overrun(loc_overrun), .loc_ovr_clr(loc_ovr_clr),
    .loc_kb_valid(loc_kb_valid), .loc_kb_ready(loc_kb_ready), .loc_kb_data(loc_kb_data),
    .loc_kb_irq(loc_kb_irq), .loc_aux_valid(loc_aux_valid), .loc_aux_ready(loc_aux_ready),
    .loc_aux_data(loc_aux_data), .loc_flush(loc_flush),
    .irq_ibf(irq_ibf), .irq_obe(irq_obe), .kbd_irq_line(kbd_irq_line)
  );

  // behavioural reference
  bit m_obf, m_ibf, m_cmd, m_aux, m_ovr, m_obe;
  int m_in, m_out, m_ph, m_cnt;

  function automatic bit kb_rdy();
    return !m_obf && !loc_flush;
  endfunction
  function automatic bit aux_rdy();
    return kb_rdy() && !loc_kb_valid;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_obf = 0; m_ibf = 0; m_cmd = 0; m_aux = 0; m_ovr = 0; m_obe = 0;
      m_in = 0; m_out = 0; m_ph = 0; m_cnt = 0;
    end else begin
      bit wr, take, kt, at, req;
      wr   = host_wr_data || host_wr_cmd;
      take = loc_in_ready && m_ibf;
      kt   = loc_kb_valid && kb_rdy();
      at   = loc_aux_valid && aux_rdy();
      req  = kt && loc_kb_irq;
      m_ovr = (m_ovr && !loc_ovr_clr) || (wr && m_ibf && !take);
      if (wr) begin m_ibf = 1; m_in = host_wdata; m_cmd = host_wr_cmd; end
      else if (take) m_ibf = 0;
      m_obe = host_rd_data && m_obf && !loc_flush;
      if (loc_flush) begin m_obf = 0; m_aux = 0; end
      else if (kt) begin m_obf = 1; m_aux = 0; m_out = loc_kb_data; end
      else if (at) begin m_obf = 1; m_aux = 1; m_out = loc_aux_data; end
      else if (host_rd_data) begin m_obf = 0; m_aux = 0; end
      if (req) begin m_ph = 1; m_cnt = 0; end
      else if (m_ph != 0) begin
        if (m_cnt == PH - 1) begin m_cnt = 0; m_ph = (m_ph == 1) ? 2 : 0; end
        else m_cnt++;
      end
    end
    #(PERIOD/4);
    if (rst_n) begin
      chk("R5/R8 status bit0", host_status[0], m_obf);
      chk("R2 status bit1", host_status[1], m_ibf);
      chk("R2 status bit3", host_status[3], m_cmd);
      chk("R6 status bit5", host_status[5], m_aux);
      chk("R1 spare status bits", host_status & 8'hD4, 0);
      chk("R3 in_valid", loc_in_valid, m_ibf);
      chk("R3 in_is_cmd", loc_in_is_cmd, m_cmd);
      if (m_ibf) chk("R2 in_data", loc_in_data, m_in);
      if (m_obf) chk("R5 host_rdata", host_rdata, m_out);
      chk("R4 overrun", loc_overrun, m_ovr);
      chk("R7 irq_obe", irq_obe, m_obe);
      chk("R9 kbd_irq_line", kbd_irq_line, m_ph != 2);
      chk("R10 irq_ibf", irq_ibf, m_ibf);
      chk("R5 kb_ready", loc_kb_ready, kb_rdy());
      chk("R6 aux_ready", loc_aux_ready, aux_rdy());
    end
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic idle();
    host_wr_data = 0; host_wr_cmd = 0; host_rd_data = 0; loc_in_ready = 0;
    loc_ovr_clr = 0; loc_kb_valid = 0; loc_kb_irq = 0; loc_aux_valid = 0; loc_flush = 0;
  endtask
  task automatic hwrite(bit cmd, logic [7:0] b);
    tick(); host_wdata = b; host_wr_cmd = cmd; host_wr_data = !cmd; tick(); idle();
  endtask
  task automatic hread(); tick(); host_rd_data = 1; tick(); idle(); endtask
  task automatic ltake(); tick(); loc_in_ready = 1; tick(); idle(); endtask
  task automatic kput(logic [7:0] b, bit irq);
    tick(); loc_kb_data = b; loc_kb_valid = 1; loc_kb_irq = irq; tick(); idle();
  endtask
  task automatic aput(logic [7:0] b);
    tick(); loc_aux_data = b; loc_aux_valid = 1; tick(); idle();
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R1 reset status", host_status, 0);
    chk("R1 reset line", kbd_irq_line, 1);
    chk("R1 reset irqs", {irq_ibf, irq_obe}, 0);
    hwrite(0, 8'h11); ltake();
    hwrite(1, 8'hA5); hwrite(0, 8'h22);          // R4 overwrite
    ltake(); tick(); loc_ovr_clr = 1; tick(); idle();
    hwrite(1, 8'h33);
    tick(); loc_in_ready = 1; host_wr_data = 1; host_wdata = 8'h44; tick(); idle(); // R3 same cycle
    ltake();
    hread();                                    // R7 read of empty buffer
    kput(8'h5A, 0); kput(8'h66, 0); hread(); hread();
    aput(8'h77); hread();
    tick(); loc_kb_valid = 1; loc_kb_data = 8'h01; loc_aux_valid = 1; loc_aux_data = 8'h02;
    tick(); idle(); hread();                    // R6 priority
    aput(8'h03); tick(); loc_flush = 1; host_rd_data = 1; tick(); idle(); // R8
    kput(8'h04, 0); tick(); loc_flush = 1; loc_kb_valid = 1; loc_kb_data = 8'h05; tick(); idle();
    kput(8'hE0, 1); repeat (2 * PH + 20) tick();   // R9 full sequence
    hread(); kput(8'hE1, 1); repeat (PH / 2) tick();
    hread(); kput(8'hE2, 1); repeat (PH + 30) tick(); // restart in low phase
    hread(); kput(8'hE3, 1); repeat (2 * PH + 10) tick();
    for (int i = 0; i < 4000; i++) begin
      tick();
      idle();
      if ($urandom_range(0, 7) == 0) begin
        if ($urandom_range(0, 1) == 1) host_wr_cmd = 1; else host_wr_data = 1;
        host_wdata = 8'($urandom);
      end
      host_rd_data  = ($urandom_range(0, 5) == 0);
      loc_in_ready  = ($urandom_range(0, 4) == 0);
      loc_kb_valid  = ($urandom_range(0, 6) == 0);
      loc_kb_data   = 8'($urandom);
      loc_kb_irq    = ($urandom_range(0, 40) == 0);
      loc_aux_valid = ($urandom_range(0, 6) == 0);
      loc_aux_data  = 8'($urandom);
      loc_flush     = ($urandom_range(0, 40) == 0);
      loc_ovr_clr   = ($urandom_range(0, 30) == 0);
    end
    tick(); idle();
    repeat (2 * PH + 10) tick();
    finish_run();
  end
endmodule